// File: doc/BRIEF.md
# Delayed Inner-Product Fault Checker

This block sits on the vector stream of a GF(2) matrix-vector multiplication ring. It detects faulty products without recomputing any of them. Each clock it may take one chunk of `CHUNK_W` consecutive vector entries for each of `NVEC` parallel vectors. With each chunk come the matching slices of two fixed vectors, a random test vector b and the product c = bᵀ·A^d that the host computes ahead of time. For every vector the block folds two running parities: the inner product with b and the inner product with c.

On the end-of-vector strobe, the b product of the current result is compared with the c product that was taken `DELAY` results earlier and is held in a delay line. The two agree for every vector whenever all products in that window are correct. The comparison yields a per-vector mismatch mask and a sticky fault bit.

The host first fills the delay line with the c products of the results it computed itself, then arms the checker. After the last real product of a chain, the ring runs `DELAY` further iterations. Those results are discarded but still checked. The block counts them and signals the end of the chain.

Top module: `ipc_fault_checker`

## Requirements
- R1: After reset, check_vld, mismatch, fault and chain_done are 0 and armed is 0; a load_done pulse sets armed in the following cycle.
- R2: A vector ends on a cycle with chunk_vld and chunk_last both high. Its b product for parallel vector v is the XOR over all its chunks of the parity of (chunk_data[v*CHUNK_W +: CHUNK_W] AND b_slice). Its c product is the same with c_slice.
- R3: The delay line holds the last DELAY values pushed into it. A push is either a pre_push of pre_data while disarmed, or the c-product mask of any vector end. Bit v of each value belongs to parallel vector v.
- R4: At a vector end while armed, check_vld is 1 in the next cycle and mismatch[v] equals the b product XOR the value pushed DELAY pushes earlier. In every other cycle check_vld and mismatch are 0.
- R5: fault becomes 1 in the cycle check_vld shows a nonzero mismatch. It stays 1 until reset or load_done, and load_done clears it.
- R6: While disarmed, vector ends produce no check and leave fault unchanged, but their c products are still pushed.
- R7: pre_push while armed has no effect on the delay line.
- R8: A vector end with chunk_final while armed starts the drain. At the DELAY-th vector end after it, chain_done pulses for one cycle in the next cycle and armed drops at the same time. All drain vectors are checked.
- R9: Cycles with chunk_vld low do not change the running products, so idle gaps inside a vector have no effect.
- R10: The NVEC parallel vectors are checked independently; a fault in one sets only its own mismatch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chunk_vld | input | 1 | A vector chunk is present |
| chunk_last | input | 1 | This chunk ends the vector |
| chunk_final | input | 1 | This vector is the last real product of the chain |
| chunk_data | input | NVEC*CHUNK_W | One chunk per parallel vector |
| b_slice | input | CHUNK_W | Test-vector slice matching the chunk |
| c_slice | input | CHUNK_W | Precomputed-vector slice matching the chunk |
| pre_push | input | 1 | Push pre_data into the delay line (disarmed only) |
| pre_data | input | NVEC | Preloaded c products, one bit per parallel vector |
| load_done | input | 1 | Delay line loaded: arm checking, clear fault |
| check_vld | output | 1 | A comparison result is present |
| mismatch | output | NVEC | Per-vector comparison failure |
| fault | output | 1 | Sticky fault indication |
| chain_done | output | 1 | Drain iterations finished |
| armed | output | 1 | Checking is enabled |

## Verification
A corrupted running parity or a misaligned delay-line entry shows up as a wrong mismatch bit one cycle after the vector end that uses it. For a delay-line fault, that is up to DELAY vectors after the bad value was pushed. The bench therefore forces later vectors to match exactly. Any mismatch bit on those vectors can only come from a stored value that was lost or reordered. A miscounting drain controller shows up as chain_done and armed changing one vector early or late.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_st_e;
endpackage

// File: rtl/ipc_dot_acc.sv
module ipc_dot_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         last,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  output logic         prod
);
  logic acc_q, acc_d, contrib;

  assign contrib = ^(data & mask);
  assign prod    = acc_q ^ contrib;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = last ? 1'b0 : prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_d;
  end

  AST_ACC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> !acc_q); // R2
  AST_ACC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q)); // R9
endmodule

// File: rtl/ipc_delay_line.sv
module ipc_delay_line #(
  parameter int DEPTH = 200,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tail
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  assign stage_d[0] = din;
  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    assign stage_d[s] = stage_q[s-1];
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage_q[s] <= '0;
      else if (push) stage_q[s] <= stage_d[s];
    end
  end

  assign tail = stage_q[DEPTH-1];

  AST_HEAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (stage_q[0] == $past(din))); // R3
  AST_HOLD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(tail)); // R7
endmodule

// File: rtl/ipc_drain_ctl.sv
module ipc_drain_ctl #(
  parameter int DELAY = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vec_end,
  input  logic armed,
  input  logic final_mark,
  output logic done_now,
  output logic done_pulse
);
  import ipc_pkg::*;
  localparam int CW = $clog2(DELAY + 1);

  drain_st_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    done_now = 1'b0;
    if (vec_end && armed) begin
      if (st_q == DR_RUN) begin
        if (cnt_q == CW'(1)) begin
          done_now = 1'b1;
          st_d     = DR_IDLE;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end else if (final_mark) begin
        st_d  = DR_RUN;
        cnt_d = CW'(DELAY);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= DR_IDLE;
      cnt_q      <= '0;
      done_pulse <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      done_pulse <= done_now;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DELAY)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R8
endmodule

// File: rtl/ipc_fault_checker.sv
module ipc_fault_checker #(
  parameter int CHUNK_W = 32,
  parameter int NVEC    = 4,
  parameter int DELAY   = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chunk_vld,
  input  logic                    chunk_last,
  input  logic                    chunk_final,
  input  logic [NVEC*CHUNK_W-1:0] chunk_data,
  input  logic [CHUNK_W-1:0]      b_slice,
  input  logic [CHUNK_W-1:0]      c_slice,
  input  logic                    pre_push,
  input  logic [NVEC-1:0]         pre_data,
  input  logic                    load_done,
  output logic                    check_vld,
  output logic [NVEC-1:0]         mismatch,
  output logic                    fault,
  output logic                    chain_done,
  output logic                    armed
);
  logic [NVEC-1:0] b_prod, c_prod, tail, line_din, mis_d;
  logic            vec_end, pre_take, line_push, done_now;
  logic            armed_q, armed_d, fault_q, fault_d, check_d;

  assign vec_end = chunk_vld & chunk_last;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    ipc_dot_acc #(.W(CHUNK_W)) u_b_acc (
      .clk(clk), .rst_n(rst_n), .en(chunk_vld), .last(chunk_last),
      .data(chunk_data[v*CHUNK_W +: CHUNK_W]), .mask(b_slice), .prod(b_prod[v]));
    ipc_dot_acc #(.W(CHUNK_W)) u_c_acc (
      .clk(clk), .rst_n(rst_n), .en(chunk_vld), .last(chunk_last),
      .data(chunk_data[v*CHUNK_W +: CHUNK_W]), .mask(c_slice), .prod(c_prod[v]));
  end

  assign pre_take  = pre_push & ~armed_q & ~vec_end;
  assign line_push = vec_end | pre_take;
  assign line_din  = vec_end ? c_prod : pre_data;

  ipc_delay_line #(.DEPTH(DELAY), .WIDTH(NVEC)) u_line (
    .clk(clk), .rst_n(rst_n), .push(line_push), .din(line_din), .tail(tail));

  ipc_drain_ctl #(.DELAY(DELAY)) u_drain (
    .clk(clk), .rst_n(rst_n), .vec_end(vec_end), .armed(armed_q),
    .final_mark(chunk_final), .done_now(done_now), .done_pulse(chain_done));

  always_comb begin
    check_d = vec_end & armed_q;
    mis_d   = check_d ? (b_prod ^ tail) : '0;
    fault_d = load_done ? 1'b0 : (fault_q | (|mis_d));
    armed_d = armed_q;
    if (done_now)  armed_d = 1'b0;
    if (load_done) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      fault_q   <= 1'b0;
      check_vld <= 1'b0;
      mismatch  <= '0;
    end else begin
      armed_q   <= armed_d;
      fault_q   <= fault_d;
      check_vld <= check_d;
      mismatch  <= mis_d;
    end
  end

  assign fault = fault_q;
  assign armed = armed_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !load_done) |=> fault_q); // R5
  AST_MISMATCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (check_vld && (|mismatch)) |-> fault); // R5
  AST_CHECK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    check_vld |-> $past(armed_q)); // R6
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !check_vld |-> (mismatch == '0)); // R4
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_done && !$past(load_done)) |-> !armed_q); // R8
endmodule

// File: tb/ipc_fault_checker_bench.sv
module ipc_fault_checker_bench;
  localparam int CW = 8;
  localparam int NV = 2;
  localparam int DL = 4;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chunk_vld = 0, chunk_last = 0, chunk_final = 0, pre_push = 0, load_done = 0;
  logic [NV*CW-1:0] chunk_data = '0;
  logic [CW-1:0] b_slice = '0, c_slice = '0;
  logic [NV-1:0] pre_data = '0;
  logic check_vld, fault, chain_done, armed;
  logic [NV-1:0] mismatch;

  always #5 clk = ~clk;

  ipc_fault_checker #(.CHUNK_W(CW), .NVEC(NV), .DELAY(DL)) u_ipc_fault_checker (
    .clk(clk), .rst_n(rst_n), .chunk_vld(chunk_vld), .chunk_last(chunk_last),
    .chunk_final(chunk_final), .chunk_data(chunk_data), .b_slice(b_slice),
    .c_slice(c_slice), .pre_push(pre_push), .pre_data(pre_data), .load_done(load_done),
    .check_vld(check_vld), .mismatch(mismatch), .fault(fault),
    .chain_done(chain_done), .armed(armed));

  int n_chk = 0, n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [NV-1:0] mline [DL];
  logic m_armed = 0, m_fault = 0, m_drain = 0;
  int   m_cnt = 0;

  function automatic logic [CW-1:0] b_pat(input int ci);
    case (ci) 0: return 8'hA5; 1: return 8'h3C; default: return 8'hF0; endcase
  endfunction
  function automatic logic [CW-1:0] c_pat(input int ci);
    case (ci) 0: return 8'h5A; 1: return 8'h0F; default: return 8'h99; endcase
  endfunction

  function automatic logic par(input logic [CW-1:0] x);
    logic p = 1'b0;
    for (int i = 0; i < CW; i++) p = p ^ x[i];
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_push(input logic [NV-1:0] val);
    for (int j = DL-1; j > 0; j--) mline[j] = mline[j-1];
    mline[0] = val;
  endtask

  // force: make the b product equal the delayed entry xor flip
  task automatic send_vector(input string req, input logic force_m, input logic [NV-1:0] flip,
                             input logic fin, input int gap);
    logic [CW-1:0] d [NCH][NV];
    logic [NV-1:0] bp, cp, emis;
    logic edone;
    bp = '0; cp = '0; emis = '0; edone = 1'b0;
    for (int ci = 0; ci < NCH; ci++)
      for (int v = 0; v < NV; v++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        d[ci][v] = seed[23:16];
      end
    for (int v = 0; v < NV; v++) begin
      for (int ci = 0; ci < NCH; ci++) bp[v] = bp[v] ^ par(d[ci][v] & b_pat(ci));
      if (force_m && m_armed && (bp[v] != (mline[DL-1][v] ^ flip[v]))) begin
        d[0][v][0] = ~d[0][v][0];
        bp[v] = ~bp[v];
      end
      for (int ci = 0; ci < NCH; ci++) cp[v] = cp[v] ^ par(d[ci][v] & c_pat(ci));
    end
    if (m_armed) begin
      emis = bp ^ mline[DL-1];
      m_fault = m_fault | (|emis);
      if (m_drain) begin
        m_cnt--;
        if (m_cnt == 0) begin edone = 1'b1; m_drain = 0; end
      end else if (fin) begin
        m_drain = 1; m_cnt = DL;
      end
    end
    for (int ci = 0; ci < NCH; ci++) begin
      @(negedge clk);
      chunk_vld = 1'b1;
      chunk_last = (ci == NCH-1);
      chunk_final = fin && (ci == NCH-1);
      b_slice = b_pat(ci);
      c_slice = c_pat(ci);
      for (int v = 0; v < NV; v++) chunk_data[v*CW +: CW] = d[ci][v];
      if (ci < NCH-1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chunk_vld = 1'b0;
          chunk_data = ~chunk_data;
        end
    end
    @(negedge clk);
    chunk_vld = 0; chunk_last = 0; chunk_final = 0;
    chk({req, " check_vld/mismatch"}, {check_vld, mismatch}, {m_armed, emis});
    chk({req, " fault"}, fault, m_fault);
    chk({req, " chain_done"}, chain_done, edone);
    if (edone) m_armed = 0;
    chk({req, " armed"}, armed, m_armed);
    model_push(cp);
  endtask

  task automatic preload(input string req, input logic [NV-1:0] val);
    @(negedge clk);
    pre_push = 1'b1; pre_data = val;
    @(negedge clk);
    pre_push = 1'b0;
    if (!m_armed) model_push(val);
    chk({req, " armed unchanged"}, armed, m_armed);
  endtask

  task automatic arm(input string req);
    @(negedge clk);
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
    m_armed = 1; m_fault = 0;
    chk({req, " armed"}, armed, 1);
    chk({req, " fault cleared"}, fault, 0);
  endtask

  task automatic t_reset();
    for (int j = 0; j < DL; j++) mline[j] = '0;
    repeat (3) @(negedge clk);
    chk("R1 check_vld", check_vld, 0);
    chk("R1 mismatch", mismatch, 0);
    chk("R1 fault", fault, 0);
    chk("R1 chain_done", chain_done, 0);
    chk("R1 armed", armed, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_unarmed();
    send_vector("R6 disarmed vector", 1'b0, '0, 1'b0, 0);
    send_vector("R6 disarmed vector", 1'b0, '0, 1'b1, 0);
  endtask

  task automatic t_preload_and_match();
    preload("R3 preload", 2'b01);
    preload("R3 preload", 2'b10);
    arm("R1 arm");
    for (int i = 0; i < 4; i++) send_vector("R4 R2 matching", 1'b1, '0, 1'b0, 0);
  endtask

  task automatic t_fault();
    send_vector("R10 R5 lane1 fault", 1'b1, 2'b10, 1'b0, 0);
    send_vector("R5 sticky", 1'b1, '0, 1'b0, 0);
    send_vector("R10 lane0 fault", 1'b1, 2'b01, 1'b0, 0);
  endtask

  task automatic t_preload_armed();
    preload("R7 preload armed", 2'b11);
    preload("R7 preload armed", 2'b11);
    for (int i = 0; i < DL; i++) send_vector("R7 line intact", 1'b1, '0, 1'b0, 0);
  endtask

  task automatic t_gap();
    send_vector("R9 gap", 1'b1, '0, 1'b0, 2);
    send_vector("R9 gap", 1'b1, 2'b11, 1'b0, 1);
  endtask

  task automatic t_drain();
    arm("R5 load_done clears");
    send_vector("R8 final", 1'b1, '0, 1'b1, 0);
    for (int i = 0; i < DL; i++) send_vector("R8 drain", 1'b1, '0, 1'b0, 0);
    send_vector("R8 R6 after chain", 1'b0, '0, 1'b0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_unarmed();
    t_preload_and_match();
    t_fault();
    t_preload_armed();
    t_gap();
    t_drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule